// File: doc/BRIEF.md
# Register Tag and Busy Table

This block keeps the architectural floating-point register file of an out-of-order floating-point cluster: four 64-bit registers. Each register has a busy flag, a 4-bit producer tag and a precision flag. When the decoder issues an operation, the table gives the chosen reservation station either the current value of each operand register or, if that register is still waiting on a producer, the tag of that producer. In the same step it renames the destination register to the issuing station's tag.

The table watches the shared result bus. A busy register takes the broadcast data only when the broadcast tag equals the tag it holds now. Because of this, a register that has been renamed by a later issue ignores any older producer. Loads rename the destination to the fetch buffer that will deliver the operand. Register-to-register moves need no execution unit: a move from a waiting register copies the producer tag, and a move from a settled register copies the value. The table raises a stall when an instruction of one precision targets a register whose outstanding writer has the other precision.

The operand outputs are combinational views of the issue inputs. A result broadcast in the current cycle is forwarded into these views. The issue takes effect when `iss_valid` is high and `stall` is low.

Top module: `fprt_table`

## Requirements
- R1: After reset every register is not busy and holds zero, so both operand ports report ready with value 0 and `stall` is 0.
- R2: An arithmetic issue (`iss_kind` = 2'b00) that is not stalled marks register `iss_sink` busy with tag `iss_tag` and precision `iss_dbl`. Port A reads register `iss_sink` and port B reads register `iss_src`. Each port gives ready=1 with the value when its register is settled, or ready=0 with the register's tag when it is busy.
- R3: When `res_valid` is high and a busy register holds a tag equal to `res_tag`, that register takes `res_data` and becomes not busy. A register that is not busy ignores every broadcast.
- R4: A register renamed by a later issue ignores a broadcast of its earlier producer's tag and keeps its new tag.
- R5: A load (`iss_kind` = 2'b01) marks `iss_sink` busy with tag `iss_tag`, even when that register is already busy under a different tag.
- R6: A move (`iss_kind` = 2'b10) from a busy source gives the destination `iss_sink` the source's tag and makes it busy. A later broadcast of that tag then settles both registers with the same data.
- R7: A move from a settled source copies its value into `iss_sink` and leaves the destination not busy.
- R8: `stall` is 1 when `iss_valid` is high, the kind is not a store, register `iss_sink` is busy, and its precision flag differs from `iss_dbl`. A stalled issue changes no register.
- R9: When an issue and a matching broadcast reach the same destination register in one cycle, the issue wins: the register ends busy with the new tag.
- R10: An operand read of a register whose tag is being broadcast in the same cycle reports ready with `res_data`. The stall test of R8 uses this forwarded busy state.
- R11: A store (`iss_kind` = 2'b11) reads `iss_sink` on port A, never stalls, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_kind | input | 2 | 00 arithmetic, 01 load, 10 move, 11 store |
| iss_sink | input | 2 | Destination register (store: data register) |
| iss_src | input | 2 | Second operand register, or move source |
| iss_tag | input | 4 | Tag of the chosen station or fetch buffer |
| iss_dbl | input | 1 | 1 for double precision, 0 for single |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | 4 | Tag of the unit driving the result bus |
| res_data | input | 64 | Result bus data |
| opa_ready | output | 1 | Port A operand is a value |
| opa_value | output | 64 | Port A operand value |
| opa_tag | output | 4 | Port A producer tag when not ready |
| opb_ready | output | 1 | Port B operand is a value |
| opb_value | output | 64 | Port B operand value |
| opb_tag | output | 4 | Port B producer tag when not ready |
| stall | output | 1 | Decode must hold the issue |

## Verification
Renaming at issue and capture from the result bus can hit the same register in the same cycle. The bench provokes this by broadcasting the tag a waiting register holds while an arithmetic issue targets that register with the opposite precision. Three things are judged from this one cycle. The stall must stay low, because the forwarded view says the register is settling. Port A must show the broadcast value. A later read must show the register busy under the new tag and not holding the broadcast data. The same kind of overlap is also driven on operand reads alone, and a broadcast of a stale tag is sent on a renamed register to confirm that nothing is captured.

// File: rtl/fprt_pkg.sv
package fprt_pkg;
   typedef enum logic [1:0] {
      OP_ARITH = 2'b00,
      OP_LOAD  = 2'b01,
      OP_MOVE  = 2'b10,
      OP_STORE = 2'b11
   } op_kind_e;

   function automatic logic kind_writes(input op_kind_e k);
      return k != OP_STORE;
   endfunction
endpackage

// File: rtl/fprt_cell.sv
module fprt_cell #(
   parameter int DW = 64,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_busy,
   input  logic [TW-1:0] wr_tag,
   input  logic          wr_dbl,
   input  logic [DW-1:0] wr_data,
   input  logic          res_valid,
   input  logic [TW-1:0] res_tag,
   input  logic [DW-1:0] res_data,
   output logic          busy_q,
   output logic [TW-1:0] tag_q,
   output logic          dbl_q,
   output logic          eff_busy,
   output logic [DW-1:0] eff_data
);
   logic [DW-1:0] data_q;
   logic          hit;

   assign hit      = busy_q && res_valid && (tag_q == res_tag);
   assign eff_busy = busy_q && !hit;
   assign eff_data = hit ? res_data : data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tag_q  <= '0;
         dbl_q  <= 1'b0;
         data_q <= '0;
      end else if (wr_en) begin
         busy_q <= wr_busy;
         tag_q  <= wr_tag;
         dbl_q  <= wr_dbl;
         if (!wr_busy) data_q <= wr_data;
         else if (hit) data_q <= res_data;
      end else if (hit) begin
         busy_q <= 1'b0;
         data_q <= res_data;
      end
   end
endmodule

// File: rtl/fprt_port.sv
module fprt_port #(
   parameter int NREG = 4,
   parameter int DW   = 64,
   parameter int TW   = 4,
   localparam int IW  = $clog2(NREG)
) (
   input  logic [IW-1:0]             sel,
   input  logic [NREG-1:0]           eff_busy,
   input  logic [NREG-1:0][DW-1:0]   eff_data,
   input  logic [NREG-1:0][TW-1:0]   tag_arr,
   output logic                      ready,
   output logic [DW-1:0]             value,
   output logic [TW-1:0]             tag
);
   assign ready = !eff_busy[sel];
   assign value = eff_data[sel];
   assign tag   = tag_arr[sel];
endmodule

// File: rtl/fprt_issue.sv
module fprt_issue
   import fprt_pkg::*;
#(
   parameter int NREG = 4,
   parameter int DW   = 64,
   parameter int TW   = 4,
   localparam int IW  = $clog2(NREG)
) (
   input  logic            iss_valid,
   input  logic [1:0]      iss_kind,
   input  logic [IW-1:0]   iss_sink,
   input  logic [TW-1:0]   iss_tag,
   input  logic            iss_dbl,
   input  logic            sink_busy,
   input  logic            sink_dbl,
   input  logic            src_ready,
   input  logic [DW-1:0]   src_value,
   input  logic [TW-1:0]   src_tag,
   output logic            stall,
   output logic [NREG-1:0] wr_sel,
   output logic            wr_busy,
   output logic [TW-1:0]   wr_tag,
   output logic            wr_dbl,
   output logic [DW-1:0]   wr_data
);
   op_kind_e kind;
   logic     writes;
   logic     fire;

   assign kind   = op_kind_e'(iss_kind);
   assign writes = kind_writes(kind);
   assign stall  = iss_valid && writes && sink_busy && (sink_dbl != iss_dbl);
   assign fire   = iss_valid && writes && !stall;
   assign wr_dbl = iss_dbl;

   always_comb begin
      for (int i = 0; i < NREG; i++)
         wr_sel[i] = fire && (iss_sink == IW'(i));
   end

   always_comb begin
      wr_busy = 1'b1;
      wr_tag  = iss_tag;
      wr_data = src_value;
      if (kind == OP_MOVE) begin
         wr_busy = !src_ready;
         wr_tag  = src_tag;
      end
   end
endmodule

// File: rtl/fprt_table.sv
module fprt_table #(
   parameter int NREG = 4,
   parameter int DW   = 64,
   parameter int TW   = 4,
   localparam int IW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          iss_valid,
   input  logic [1:0]    iss_kind,
   input  logic [IW-1:0] iss_sink,
   input  logic [IW-1:0] iss_src,
   input  logic [TW-1:0] iss_tag,
   input  logic          iss_dbl,
   input  logic          res_valid,
   input  logic [TW-1:0] res_tag,
   input  logic [DW-1:0] res_data,
   output logic          opa_ready,
   output logic [DW-1:0] opa_value,
   output logic [TW-1:0] opa_tag,
   output logic          opb_ready,
   output logic [DW-1:0] opb_value,
   output logic [TW-1:0] opb_tag,
   output logic          stall
);
   if (NREG < 2) begin : g_bad_nreg
      $error("fprt_table: NREG must be at least 2");
   end
   if (TW < 1 || DW < 1) begin : g_bad_width
      $error("fprt_table: TW and DW must be positive");
   end

   logic [NREG-1:0]         busy_vec;
   logic [NREG-1:0][TW-1:0] tag_arr;
   logic [NREG-1:0]         dbl_vec;
   logic [NREG-1:0]         eff_busy;
   logic [NREG-1:0][DW-1:0] eff_data;
   logic [NREG-1:0]         wr_sel;
   logic                    wr_busy;
   logic [TW-1:0]           wr_tag;
   logic                    wr_dbl;
   logic [DW-1:0]           wr_data;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      fprt_cell #(.DW(DW), .TW(TW)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_sel[g]),
         .wr_busy  (wr_busy),
         .wr_tag   (wr_tag),
         .wr_dbl   (wr_dbl),
         .wr_data  (wr_data),
         .res_valid(res_valid),
         .res_tag  (res_tag),
         .res_data (res_data),
         .busy_q   (busy_vec[g]),
         .tag_q    (tag_arr[g]),
         .dbl_q    (dbl_vec[g]),
         .eff_busy (eff_busy[g]),
         .eff_data (eff_data[g])
      );
   end

   fprt_port #(.NREG(NREG), .DW(DW), .TW(TW)) u_port_a (
      .sel(iss_sink), .eff_busy(eff_busy), .eff_data(eff_data), .tag_arr(tag_arr),
      .ready(opa_ready), .value(opa_value), .tag(opa_tag)
   );

   fprt_port #(.NREG(NREG), .DW(DW), .TW(TW)) u_port_b (
      .sel(iss_src), .eff_busy(eff_busy), .eff_data(eff_data), .tag_arr(tag_arr),
      .ready(opb_ready), .value(opb_value), .tag(opb_tag)
   );

   fprt_issue #(.NREG(NREG), .DW(DW), .TW(TW)) u_issue (
      .iss_valid(iss_valid),
      .iss_kind (iss_kind),
      .iss_sink (iss_sink),
      .iss_tag  (iss_tag),
      .iss_dbl  (iss_dbl),
      .sink_busy(!opa_ready),
      .sink_dbl (dbl_vec[iss_sink]),
      .src_ready(opb_ready),
      .src_value(opb_value),
      .src_tag  (opb_tag),
      .stall    (stall),
      .wr_sel   (wr_sel),
      .wr_busy  (wr_busy),
      .wr_tag   (wr_tag),
      .wr_dbl   (wr_dbl),
      .wr_data  (wr_data)
   );
endmodule

// File: rtl/fprt_chk.sv
module fprt_chk #(
   parameter int NREG = 4,
   parameter int TW   = 4,
   localparam int IW  = $clog2(NREG)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    iss_valid,
   input logic [1:0]              iss_kind,
   input logic [IW-1:0]           iss_sink,
   input logic [TW-1:0]           iss_tag,
   input logic                    res_valid,
   input logic [TW-1:0]           res_tag,
   input logic                    opa_ready,
   input logic                    stall,
   input logic [NREG-1:0]         busy_vec,
   input logic [NREG-1:0][TW-1:0] tag_arr
);
   logic fire;
   assign fire = iss_valid && !stall && (iss_kind != 2'b11);

   // R1
   reset_clear_chk: assert property (@(posedge clk) !rst_n |=> busy_vec == '0);

   // R2
   arith_rename_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire && iss_kind == 2'b00 |=> busy_vec[$past(iss_sink)] && tag_arr[$past(iss_sink)] == $past(iss_tag));

   // R5
   load_rename_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire && iss_kind == 2'b01 |=> busy_vec[$past(iss_sink)] && tag_arr[$past(iss_sink)] == $past(iss_tag));

   // R8
   stall_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> iss_valid && busy_vec[iss_sink]);

   // R8
   stall_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall && !res_valid |=> $stable(busy_vec) && $stable(tag_arr));

   // R11
   store_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && iss_kind == 2'b11 && !res_valid |=> $stable(busy_vec) && $stable(tag_arr));

   // R10
   opa_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !opa_ready |-> busy_vec[iss_sink]);

   for (genvar g = 0; g < NREG; g++) begin : g_reg_chk
      // R3
      capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid && busy_vec[g] && tag_arr[g] == res_tag && !(fire && iss_sink == IW'(g))
         |=> !busy_vec[g]);
      // R4
      stale_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
         busy_vec[g] && !(res_valid && tag_arr[g] == res_tag) && !(fire && iss_sink == IW'(g))
         |=> busy_vec[g] && $stable(tag_arr[g]));
   end
endmodule

bind fprt_table fprt_chk #(.NREG(NREG), .TW(TW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iss_valid(iss_valid),
   .iss_kind (iss_kind),
   .iss_sink (iss_sink),
   .iss_tag  (iss_tag),
   .res_valid(res_valid),
   .res_tag  (res_tag),
   .opa_ready(opa_ready),
   .stall    (stall),
   .busy_vec (busy_vec),
   .tag_arr  (tag_arr)
);

// File: tb/fprt_table_bench.sv
module fprt_table_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic [1:0]  iss_kind = 2'b00;
   logic [1:0]  iss_sink = '0;
   logic [1:0]  iss_src = '0;
   logic [3:0]  iss_tag = '0;
   logic        iss_dbl = 1'b0;
   logic        res_valid = 1'b0;
   logic [3:0]  res_tag = '0;
   logic [63:0] res_data = '0;
   logic        opa_ready, opb_ready, stall;
   logic [63:0] opa_value, opb_value;
   logic [3:0]  opa_tag, opb_tag;

   always #4 clk = ~clk;

   fprt_table u_fprt_table (.*);

   typedef struct {
      string       req;
      bit          ca; bit ar; logic [63:0] a;
      bit          cb; bit br; logic [63:0] b;
      bit          cs; bit sv;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   function automatic exp_t mk(string req, bit ca, bit ar, logic [63:0] a,
                               bit cb, bit br, logic [63:0] b, bit cs, bit sv);
      exp_t e;
      e.req = req; e.ca = ca; e.ar = ar; e.a = a;
      e.cb = cb; e.br = br; e.b = b; e.cs = cs; e.sv = sv;
      return e;
   endfunction

   task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: sets inputs for one cycle and queues what the outputs must show
   task automatic step(bit v, logic [1:0] k, int s, int r, logic [3:0] t, bit d,
                       bit rv, logic [3:0] rt, logic [63:0] rd, exp_t e);
      @(negedge clk);
      iss_valid = v; iss_kind = k; iss_sink = 2'(s); iss_src = 2'(r);
      iss_tag = t; iss_dbl = d;
      res_valid = rv; res_tag = rt; res_data = rd;
      exp_q.push_back(e);
   endtask

   // monitor: samples mid-cycle, pops the expectation for this cycle
   always @(negedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         if (e.ca) begin
            cmp(e.req, "opa_ready", 64'(opa_ready), 64'(e.ar));
            if (e.ar) cmp(e.req, "opa_value", opa_value, e.a);
            else      cmp(e.req, "opa_tag", 64'(opa_tag), e.a);
         end
         if (e.cb) begin
            cmp(e.req, "opb_ready", 64'(opb_ready), 64'(e.br));
            if (e.br) cmp(e.req, "opb_value", opb_value, e.b);
            else      cmp(e.req, "opb_tag", 64'(opb_tag), e.b);
         end
         if (e.cs) cmp(e.req, "stall", 64'(stall), 64'(e.sv));
      end
   end

   localparam logic [1:0] K_AR = 2'b00, K_LD = 2'b01, K_MV = 2'b10, K_ST = 2'b11;
   exp_t nochk;

   initial begin
      nochk = mk("none", 0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state
      step(0, K_ST, 0, 1, 0, 0, 0, 0, 0, mk("R1", 1, 1, 0, 1, 1, 0, 1, 0));
      step(0, K_ST, 2, 3, 0, 0, 0, 0, 0, mk("R1", 1, 1, 0, 1, 1, 0, 0, 0));
      // R5: load r0 with fetch buffer tag 1, double
      step(1, K_LD, 0, 1, 4'd1, 1, 0, 0, 0, mk("R5", 0, 0, 0, 0, 0, 0, 1, 0));
      step(0, K_ST, 0, 1, 0, 0, 0, 0, 0, mk("R5", 1, 0, 1, 0, 0, 0, 0, 0));
      // R10: broadcast tag 1 forwarded to port A
      step(0, K_ST, 0, 1, 0, 0, 1, 4'd1, 64'h11, mk("R10", 1, 1, 64'h11, 1, 1, 0, 0, 0));
      // R3: captured
      step(0, K_ST, 0, 1, 0, 0, 0, 0, 0, mk("R3", 1, 1, 64'h11, 0, 0, 0, 0, 0));
      // R2: arith r0 <- r0 op r1, tag 10, then again with tag 11
      step(1, K_AR, 0, 1, 4'd10, 1, 0, 0, 0, mk("R2", 1, 1, 64'h11, 1, 1, 0, 1, 0));
      step(1, K_AR, 0, 1, 4'd11, 1, 0, 0, 0, mk("R2", 1, 0, 10, 1, 1, 0, 1, 0));
      step(0, K_ST, 0, 1, 0, 0, 0, 0, 0, mk("R2", 1, 0, 11, 0, 0, 0, 0, 0));
      // R4: old producer 10 broadcasts; r0 must stay on tag 11
      step(0, K_ST, 0, 1, 0, 0, 1, 4'd10, 64'hAA, mk("R4", 1, 0, 11, 0, 0, 0, 0, 0));
      step(0, K_ST, 0, 1, 0, 0, 0, 0, 0, mk("R4", 1, 0, 11, 0, 0, 0, 0, 0));
      // R6: move r2 <- r0 while r0 waits on tag 11
      step(1, K_MV, 2, 0, 0, 1, 0, 0, 0, mk("R6", 0, 0, 0, 1, 0, 11, 1, 0));
      step(0, K_ST, 2, 0, 0, 0, 0, 0, 0, mk("R6", 1, 0, 11, 0, 0, 0, 0, 0));
      step(0, K_ST, 0, 2, 0, 0, 1, 4'd11, 64'hBB, mk("R6", 1, 1, 64'hBB, 1, 1, 64'hBB, 0, 0));
      step(0, K_ST, 0, 2, 0, 0, 0, 0, 0, mk("R6", 1, 1, 64'hBB, 1, 1, 64'hBB, 0, 0));
      // R7: move r3 <- r2 (settled)
      step(1, K_MV, 3, 2, 0, 1, 0, 0, 0, nochk);
      step(0, K_ST, 3, 0, 0, 0, 0, 0, 0, mk("R7", 1, 1, 64'hBB, 0, 0, 0, 0, 0));
      // R8: single-precision load r1 (tag 2), then a double arith to r1 stalls
      step(1, K_LD, 1, 0, 4'd2, 0, 0, 0, 0, nochk);
      step(1, K_AR, 1, 0, 4'd9, 1, 0, 0, 0, mk("R8", 0, 0, 0, 0, 0, 0, 1, 1));
      step(0, K_AR, 1, 0, 4'd9, 1, 0, 0, 0, mk("R8", 1, 0, 2, 0, 0, 0, 1, 0));
      // R9/R10: tag 2 broadcast while the double arith targets r1
      step(1, K_AR, 1, 0, 4'd9, 1, 1, 4'd2, 64'h22, mk("R9", 1, 1, 64'h22, 0, 0, 0, 1, 0));
      step(0, K_ST, 1, 0, 0, 0, 0, 0, 0, mk("R9", 1, 0, 9, 0, 0, 0, 0, 0));
      step(0, K_ST, 1, 0, 0, 0, 1, 4'd9, 64'h99, nochk);
      step(0, K_ST, 1, 0, 0, 0, 0, 0, 0, mk("R3", 1, 1, 64'h99, 0, 0, 0, 0, 0));
      // R11: store reads r1, no change; R3: broadcast on settled r1 ignored
      step(1, K_ST, 1, 0, 0, 0, 0, 0, 0, mk("R11", 1, 1, 64'h99, 0, 0, 0, 1, 0));
      step(0, K_ST, 1, 0, 0, 0, 1, 4'd9, 64'h55, mk("R11", 1, 1, 64'h99, 0, 0, 0, 0, 0));
      step(0, K_ST, 1, 0, 0, 0, 0, 0, 0, mk("R3", 1, 1, 64'h99, 0, 0, 0, 0, 0));
      // R5: load over a busy register with another tag
      step(1, K_AR, 2, 0, 4'd12, 1, 0, 0, 0, nochk);
      step(1, K_LD, 2, 0, 4'd3, 1, 0, 0, 0, mk("R5", 1, 0, 12, 0, 0, 0, 1, 0));
      step(0, K_ST, 2, 0, 0, 0, 0, 0, 0, mk("R5", 1, 0, 3, 0, 0, 0, 0, 0));
      step(0, K_ST, 2, 0, 0, 0, 1, 4'd12, 64'hCC, mk("R4", 1, 0, 3, 0, 0, 0, 0, 0));
      step(0, K_ST, 2, 0, 0, 0, 0, 0, 0, mk("R4", 1, 0, 3, 0, 0, 0, 0, 0));
      step(0, K_ST, 0, 0, 0, 0, 0, 0, 0, nochk);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule